// File: doc/BRIEF.md
# Column Ones-Counting Multi-Operand Accumulator

This block adds up a stream of unsigned operands, taking one operand per clock, without any carry chain in its accumulation loop. Each bit column of the operand has its own small counter. That counter advances by one in every accepted cycle in which its column bit is set. The loop is therefore one increment per column, and no adder spans the operand width.

When a stream closes, the column counts are captured into a holding register and the counters restart at once. A stream closes on a flagged final operand, or automatically on the maximum operand count. In the following stages the captured counts are spread onto their binary weights and folded to two rows by a layered 3:2 carry-save tree. A single carry-propagate add then produces the full-width total. A new stream can start in the cycle after the previous one closes, while the earlier total is still in the pipeline.

Top module: `colsum_accum`

## Requirements
- R1: While reset is held low, `sum_valid` is 0, `sum_out` is 0 and every column count is zero.
- R2: In a cycle with `op_valid` high, the count of column c grows by exactly one when `op_data[c]` is 1 and is unchanged otherwise. With `op_valid` low, no count changes and the data bus has no effect on any later result.
- R3: Each reported `sum_out` equals the arithmetic sum of the operands of its stream. It is OP_W + clog2(MAX_OPS+1) bits wide and never wraps, even when every operand is all ones.
- R4: A stream closes on an accepted operand with `op_last` high, or on its MAX_OPS-th accepted operand when `op_last` is low. The next accepted operand begins a new stream from zero.
- R5: If the closing operand is presented in cycle t, `sum_valid` is high in cycle t+3. It is high in no cycle that is not three cycles after a closing operand.
- R6: Streams may follow each other with no idle cycle between them, and each result is independent of its neighbours.
- R7: A stream closed early by `op_last`, with fewer than MAX_OPS operands (one operand included), reports the sum of only the operands received.
- R8: The captured column counts change only on the clock edge that closes a stream, so counting activity never reaches the reduction tree.
- R9: `sum_out` keeps the last reported total in every cycle in which `sum_valid` is low.
- R10: `op_last` with `op_valid` low is ignored: the stream stays open and keeps accumulating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | The operand on `op_data` is accepted this cycle |
| op_last | input | 1 | Marks the accepted operand as the final one of its stream |
| op_data | input | OP_W | Unsigned operand |
| sum_out | output | OP_W+clog2(MAX_OPS+1) | Total of the most recent stream |
| sum_valid | output | 1 | One-cycle pulse marking a new total on `sum_out` |

## Verification
The hardest case to reach from the ports is a stream that closes while the previous stream's total is still in flight in the reduction stages. The same applies to a stream that closes by reaching the maximum count rather than by flag. Both test whether the counters really clear as the capture happens. The stimulus therefore runs back-to-back streams of random lengths with no gap, and runs a twelve-operand burst with a single late `op_last`, which must split into a full stream and a short one. Idle bubbles carrying random data and stray `op_last` pulses are placed mid-stream, so that ignored inputs would show up in the totals.

// File: rtl/colsum_pkg.sv
package colsum_pkg;

  // bits needed to hold a count of 0..n
  function automatic int cnt_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // rows left after one layer of 3:2 compression
  function automatic int rows_after(input int r);
    return (r / 3) * 2 + (r % 3);
  endfunction

  // number of rows present at the input of a given layer
  function automatic int rows_at(input int r, input int layer);
    int x;
    x = r;
    for (int i = 0; i < layer; i++) x = rows_after(x);
    return x;
  endfunction

  // layers required to reach two rows or fewer
  function automatic int csa_layers(input int r);
    int x;
    int l;
    x = r;
    l = 0;
    while (x > 2) begin
      x = rows_after(x);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/colsum_counter.sv
module colsum_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  assign cnt_nxt = cnt + CW'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt_nxt;
  end

endmodule

// File: rtl/colsum_csa_tree.sv
module colsum_csa_tree #(
  parameter int W    = 12,
  parameter int ROWS = 4
) (
  input  logic [W-1:0] rows_in [ROWS],
  output logic [W-1:0] row_a,
  output logic [W-1:0] row_b
);

  localparam int NL    = colsum_pkg::csa_layers(ROWS);
  localparam int FINAL = colsum_pkg::rows_at(ROWS, NL);

  function automatic logic [W-1:0] csa_sum(input logic [W-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [W-1:0] csa_cry(input logic [W-1:0] a, b, c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  logic [W-1:0] lay [NL+1][ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_in
    assign lay[0][r] = rows_in[r];
  end

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int RC = colsum_pkg::rows_at(ROWS, l);
    localparam int G  = RC / 3;
    localparam int LO = RC - 3 * G;
    for (genvar g = 0; g < G; g++) begin : g_grp
      assign lay[l+1][2*g]   = csa_sum(lay[l][3*g], lay[l][3*g+1], lay[l][3*g+2]);
      assign lay[l+1][2*g+1] = csa_cry(lay[l][3*g], lay[l][3*g+1], lay[l][3*g+2]);
    end
    for (genvar p = 0; p < LO; p++) begin : g_pass
      assign lay[l+1][2*G+p] = lay[l][3*G+p];
    end
    for (genvar u = 2*G + LO; u < ROWS; u++) begin : g_zero
      assign lay[l+1][u] = '0;
    end
  end

  assign row_a = lay[NL][0];
  if (FINAL > 1) begin : g_two
    assign row_b = lay[NL][1];
  end else begin : g_one
    assign row_b = '0;
  end

endmodule

// File: rtl/colsum_accum.sv
module colsum_accum #(
  parameter int OP_W    = 8,
  parameter int MAX_OPS = 8,
  localparam int CNT_W  = colsum_pkg::cnt_bits(MAX_OPS),
  localparam int SUM_W  = OP_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_last,
  input  logic [OP_W-1:0]  op_data,
  output logic [SUM_W-1:0] sum_out,
  output logic             sum_valid
);

  localparam int ROWS   = CNT_W;
  localparam int FLAT_W = OP_W * CNT_W;

  // bit k of the count of column c lands at weight c+k
  function automatic logic [SUM_W-1:0] weigh_row(input logic [FLAT_W-1:0] flat, input int k);
    logic [SUM_W-1:0] r;
    r = '0;
    for (int c = 0; c < OP_W; c++) r[c+k] = flat[c*CNT_W+k];
    return r;
  endfunction

  // stream bookkeeping: operands seen in the open stream
  logic [CNT_W-1:0] ops_seen;
  logic             close_evt;

  assign close_evt = op_valid && (op_last || ops_seen == CNT_W'(MAX_OPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         ops_seen <= '0;
    else if (close_evt) ops_seen <= '0;
    else if (op_valid)  ops_seen <= ops_seen + 1'b1;
  end

  // column counters
  logic [FLAT_W-1:0] cnt_flat;
  logic [FLAT_W-1:0] nxt_flat;

  for (genvar c = 0; c < OP_W; c++) begin : g_col
    colsum_counter #(.CW(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (op_valid & op_data[c]),
      .clr     (close_evt),
      .cnt     (cnt_flat[c*CNT_W +: CNT_W]),
      .cnt_nxt (nxt_flat[c*CNT_W +: CNT_W])
    );
  end

  // capture stage: loads only on the closing edge
  logic [FLAT_W-1:0] lat_flat;
  logic              lat_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_flat <= '0;
      lat_vld  <= 1'b0;
    end else begin
      lat_vld <= close_evt;
      if (close_evt) lat_flat <= nxt_flat;
    end
  end

  // weight placement and carry-save reduction
  logic [SUM_W-1:0] pp_rows [ROWS];
  logic [SUM_W-1:0] red_a, red_b;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    assign pp_rows[k] = weigh_row(lat_flat, k);
  end

  colsum_csa_tree #(.W(SUM_W), .ROWS(ROWS)) u_tree (
    .rows_in (pp_rows),
    .row_a   (red_a),
    .row_b   (red_b)
  );

  // two-row register, then the carry-propagate add
  logic [SUM_W-1:0] row_a_q, row_b_q;
  logic             row_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_a_q <= '0;
      row_b_q <= '0;
      row_vld <= 1'b0;
    end else begin
      row_vld <= lat_vld;
      if (lat_vld) begin
        row_a_q <= red_a;
        row_b_q <= red_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_out   <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= row_vld;
      if (row_vld) sum_out <= row_a_q + row_b_q;
    end
  end

endmodule

// File: rtl/colsum_accum_chk.sv
module colsum_accum_chk #(
  parameter int OP_W    = 8,
  parameter int MAX_OPS = 8,
  localparam int CNT_W  = colsum_pkg::cnt_bits(MAX_OPS),
  localparam int SUM_W  = OP_W + CNT_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  op_valid,
  input logic                  close_evt,
  input logic [OP_W*CNT_W-1:0] cnt_flat,
  input logic [OP_W*CNT_W-1:0] lat_flat,
  input logic [SUM_W-1:0]      sum_out,
  input logic                  sum_valid
);

  localparam longint TOP = longint'(MAX_OPS) * ((longint'(1) << OP_W) - 1);

  // R2: no count moves in a cycle without an operand
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cnt_flat));

  // R2: a column can never hold more than one stream's worth of ones
  for (genvar c = 0; c < OP_W; c++) begin : g_bound
    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[c*CNT_W +: CNT_W] <= CNT_W'(MAX_OPS));
  end

  // R4: counters are empty right after a stream closes
  a_r4_clear_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (cnt_flat == '0));

  // R5: result arrives three cycles after the closing operand
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |-> ##3 sum_valid);

  // R5: no result without a closing operand three cycles earlier
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> $past(close_evt, 3));

  // R3: the total stays within the largest possible stream sum
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (longint'(sum_out) <= TOP));

  // R8: captured counts are quiet except on the closing edge
  a_r8_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> $stable(lat_flat));

  // R9: output holds between results
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid |-> $stable(sum_out));

endmodule

bind colsum_accum colsum_accum_chk #(.OP_W(OP_W), .MAX_OPS(MAX_OPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .close_evt (close_evt),
  .cnt_flat  (cnt_flat),
  .lat_flat  (lat_flat),
  .sum_out   (sum_out),
  .sum_valid (sum_valid)
);

// File: tb/colsum_accum_test.sv
module colsum_accum_test;

  localparam int OP_W    = 8;
  localparam int MAX_OPS = 8;
  localparam int CNT_W   = $clog2(MAX_OPS + 1);
  localparam int SUM_W   = OP_W + CNT_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             op_valid = 1'b0;
  logic             op_last = 1'b0;
  logic [OP_W-1:0]  op_data = '0;
  logic [SUM_W-1:0] sum_out;
  logic             sum_valid;

  colsum_accum #(.OP_W(OP_W), .MAX_OPS(MAX_OPS)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_last   (op_last),
    .op_data   (op_data),
    .sum_out   (sum_out),
    .sum_valid (sum_valid)
  );

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";
  bit    done  = 1'b0;

  // behavioural reference: running sum, operand count, 3-deep result delay
  longint acc;
  int     nops;
  bit     pv [3];
  longint ps [3];
  longint hold;

  always @(posedge clk) begin
    if (!rst_n) begin
      acc = 0; nops = 0; hold = 0;
      for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; ps[i] = 0; end
    end else begin
      pv[2] = pv[1]; ps[2] = ps[1];
      pv[1] = pv[0]; ps[1] = ps[0];
      pv[0] = 1'b0;
      if (pv[2]) hold = ps[2];
      if (op_valid) begin
        acc  = acc + longint'(op_data);
        nops = nops + 1;
        if (op_last || nops == MAX_OPS) begin
          pv[0] = 1'b1; ps[0] = acc;
          acc = 0; nops = 0;
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (sum_valid !== pv[2]) begin
        bad++;
        $display("FAIL R5 [%s] sum_valid got %0b exp %0b", tag, sum_valid, pv[2]);
      end
      total++;
      if (sum_out !== SUM_W'(hold)) begin
        bad++;
        $display("FAIL R3 [%s] sum_out got %0d exp %0d", tag, sum_out, hold);
      end
    end
  end

  task automatic put(input logic [OP_W-1:0] d, input logic l, input logic v);
    @(negedge clk);
    op_valid = v; op_data = d; op_last = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(OP_W'($urandom), 1'b0, 1'b0);
  endtask

  task automatic stream(input int len, input int kind);
    for (int i = 0; i < len; i++) begin
      logic [OP_W-1:0] d;
      d = (kind == 0) ? '0 : (kind == 1) ? '1 : OP_W'($urandom);
      put(d, i == len - 1, 1'b1);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    total++;  // R1 reset state
    if (sum_valid !== 1'b0 || sum_out !== '0) begin
      bad++;
      $display("FAIL R1 reset got valid=%0b sum=%0d exp valid=0 sum=0", sum_valid, sum_out);
    end
    rst_n = 1'b1;

    tag = "R4";  // full all-zero set closing on count, no flag
    for (int i = 0; i < MAX_OPS; i++) put('0, 1'b0, 1'b1);
    idle(4);

    tag = "R3";  // all-ones set, widest total
    stream(MAX_OPS, 1);
    idle(4);

    tag = "R2";  // random sets with bubbles carrying junk data
    for (int s = 0; s < 6; s++) begin
      for (int i = 0; i < MAX_OPS; i++) begin
        put(OP_W'($urandom), i == MAX_OPS - 1, 1'b1);
        if ($urandom_range(0, 2) == 0) put(OP_W'($urandom), 1'b0, 1'b0);
      end
    end
    idle(4);

    tag = "R7";  // early close and one-operand streams
    stream(3, 2); idle(4);
    stream(1, 1); idle(4);
    stream(1, 2); idle(2);

    tag = "R6";  // back-to-back streams of varying length, no gaps
    for (int s = 0; s < 12; s++) stream($urandom_range(1, MAX_OPS), s % 3);
    idle(4);

    tag = "R4";  // twelve operands with one late flag: splits 8 + 4
    for (int i = 0; i < 12; i++) put('1, i == 11, 1'b1);
    idle(4);

    tag = "R10";  // stray flag without valid must not close the stream
    put(8'd17, 1'b0, 1'b1);
    put(8'd200, 1'b1, 1'b0);
    put(8'd33, 1'b0, 1'b1);
    put(8'd1, 1'b1, 1'b1);
    idle(4);

    tag = "R8,R9";  // long idle and a slow stream: output must hold
    idle(10);
    for (int i = 0; i < 5; i++) begin
      put(OP_W'($urandom), i == 4, 1'b1);
      idle(3);
    end
    idle(6);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired, got hung run exp completion");
      finish_run();
    end
  end

endmodule